// File: doc/BRIEF.md
# Multiply Double-Add Unit with Late Addends

This block is a pipelined unsigned arithmetic unit. It computes `a*b + c + d`, where all four operands are one word wide, and returns the result as a two-word value. With unsigned one-word operands this sum can never exceed two words, so no overflow case exists. It is the inner step of multi-precision multiply loops, where `c` is usually a carry word produced by the previous iteration.

The multiplier operands enter at issue, and the multiply starts at once, without waiting for the addends. The partial products are reduced carry-free to a pair of double-width vectors, and that pair travels through a fixed number of multiply stages. It then waits in a pending slot. The addends arrive later with a tag. When the tag matches the pending product, they are compressed together with the pair and summed by one carry-propagate adder, and the result is registered.

The result appears one cycle after the addends are accepted, so a carry word that arrives late adds a single cycle to the loop, not the whole multiply latency. The high word is the timing-critical output. Addends that find no matching pending product are ignored.

Top module: `mdadd_unit`

## Requirements
- R1: When `res_vld` is high, `{res_hi, res_lo}` equals the unsigned value `a*b + c + d`. `res_hi` holds the upper word and `res_lo` the lower word.
- R2: An issue is accepted in every cycle that `iss_vld` is high, including back-to-back cycles. It never waits for addends.
- R3: The product of an issue sampled at clock edge k is pending from edge k+MUL_STAGES onward. Addends sampled at an earlier edge find no pending product and give no result.
- R4: Addends are accepted at an edge where `add_vld` is high, a product is pending and `add_tag` equals that product's tag. `res_vld` rises right after that same edge, and it is high only after edges where addends were accepted.
- R5: Addends whose tag does not match, or that arrive while nothing is pending, are ignored: `res_vld` stays low, and a pending product remains available. A product that has been consumed cannot be consumed again.
- R6: A pending product stays available, with its value and tag unchanged, for any number of cycles until matching addends arrive.
- R7: If a new product reaches the pending slot while an earlier one is still unconsumed, the new one replaces it. The replaced product never yields a result, and its tag no longer matches.
- R8: `res_tag` equals the `iss_tag` given with the multiplier operands.
- R9: While `rst_n` is low, and after it is released, `res_vld` is low and no product is pending.
- R10: All-ones operands give all-ones in both result words, because the sum reaches exactly 2^(2*WORD_W) - 1.
- R11: At a single edge, a product can arrive in the slot while the previous one is consumed. Both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Multiplier operands valid |
| iss_tag | input | TAG_W | Tag of the issued operation |
| iss_a | input | WORD_W | Multiplicand |
| iss_b | input | WORD_W | Multiplier |
| add_vld | input | 1 | Addends valid |
| add_tag | input | TAG_W | Tag of the operation the addends belong to |
| add_c | input | WORD_W | First addend |
| add_d | input | WORD_W | Second addend |
| res_vld | output | 1 | Result valid |
| res_tag | output | TAG_W | Tag of the result |
| res_hi | output | WORD_W | Upper result word |
| res_lo | output | WORD_W | Lower result word |

## Verification
With the default of two multiply stages, a product issued at edge k can first accept addends at edge k+2. The result is visible right after the edge that accepts its addends, and `res_vld` falls after the next edge unless new addends are accepted there. The bench changes inputs 1 ns after a rising edge and reads the outputs 1 ns after the following rising edge. Each expected result and valid level is therefore tied to one specific edge. The checks count edges from issue and from addend acceptance, covering addends that are too early, late, mismatched and repeated.

// File: rtl/mdadd_pkg.sv
package mdadd_pkg;

  // Rows left after lv levels of 3:2 compression, starting from n rows.
  function automatic int rows_after(input int n, input int lv);
    int r;
    r = n;
    for (int i = 0; i < lv; i++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // Number of 3:2 levels needed to bring n rows down to two.
  function automatic int tree_depth(input int n);
    int r;
    int d;
    r = n;
    d = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/mdadd_pp_tree.sv
module mdadd_pp_tree #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]   op_a,
  input  logic [WORD_W-1:0]   op_b,
  output logic [2*WORD_W-1:0] sum_o,
  output logic [2*WORD_W-1:0] carry_o
);
  import mdadd_pkg::*;

  localparam int DW    = 2 * WORD_W;
  localparam int DEPTH = tree_depth(WORD_W);

  // Rows at every level of the carry-free reduction.
  logic [DW-1:0] lv [DEPTH+1][WORD_W];

  // Partial products: one shifted copy of op_a per set bit of op_b.
  for (genvar r = 0; r < WORD_W; r++) begin : g_pp
    assign lv[0][r] = op_b[r] ? (DW'(op_a) << r) : '0;
  end

  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int NI = rows_after(WORD_W, l);
    localparam int NG = NI / 3;
    localparam int NR = NI % 3;
    localparam int NO = 2 * NG + NR;

    for (genvar g = 0; g < NG; g++) begin : g_csa
      assign lv[l+1][2*g]   = lv[l][3*g] ^ lv[l][3*g+1] ^ lv[l][3*g+2];
      assign lv[l+1][2*g+1] = ((lv[l][3*g]   & lv[l][3*g+1]) |
                               (lv[l][3*g]   & lv[l][3*g+2]) |
                               (lv[l][3*g+1] & lv[l][3*g+2])) << 1;
    end
    for (genvar p = 0; p < NR; p++) begin : g_pass
      assign lv[l+1][NO-NR+p] = lv[l][3*NG+p];
    end
    for (genvar z = NO; z < WORD_W; z++) begin : g_zero
      assign lv[l+1][z] = '0;
    end
  end

  assign sum_o   = lv[DEPTH][0];
  assign carry_o = lv[DEPTH][1];

endmodule

// File: rtl/mdadd_prod_pipe.sv
module mdadd_prod_pipe #(
  parameter int DW     = 64,
  parameter int TAG_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [DW-1:0]    in_sum,
  input  logic [DW-1:0]    in_carry,
  input  logic             take,
  output logic             pend_vld,
  output logic [TAG_W-1:0] pend_tag,
  output logic [DW-1:0]    pend_sum,
  output logic [DW-1:0]    pend_carry
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] vld_q, vld_d, ld_en, src_vld;
  logic [TAG_W-1:0]  tag_q [STAGES];
  logic [TAG_W-1:0]  src_tag [STAGES];
  logic [DW-1:0]     sum_q [STAGES];
  logic [DW-1:0]     src_sum [STAGES];
  logic [DW-1:0]     car_q [STAGES];
  logic [DW-1:0]     src_car [STAGES];

  // Each stage loads from the issue side or from the stage before it.
  for (genvar i = 0; i < STAGES; i++) begin : g_src
    if (i == 0) begin : g_head
      assign src_vld[i] = in_vld;
      assign src_tag[i] = in_tag;
      assign src_sum[i] = in_sum;
      assign src_car[i] = in_carry;
    end else begin : g_body
      assign src_vld[i] = vld_q[i-1];
      assign src_tag[i] = tag_q[i-1];
      assign src_sum[i] = sum_q[i-1];
      assign src_car[i] = car_q[i-1];
    end
  end

  // Next state: inner stages just advance. The last stage is the pending
  // slot: it keeps its product until consumed, and a new arrival overwrites it.
  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      ld_en[i] = src_vld[i];
      if (i == LAST) vld_d[i] = src_vld[i] | (vld_q[i] & ~take);
      else           vld_d[i] = src_vld[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < STAGES; i++) begin
      if (ld_en[i]) begin
        tag_q[i] <= src_tag[i];
        sum_q[i] <= src_sum[i];
        car_q[i] <= src_car[i];
      end
    end
  end

  assign pend_vld   = vld_q[LAST];
  assign pend_tag   = tag_q[LAST];
  assign pend_sum   = sum_q[LAST];
  assign pend_carry = car_q[LAST];

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !take && !src_vld[LAST]) |=>
      (pend_vld && $stable(pend_tag) && $stable(pend_sum) && $stable(pend_carry))); // R6

  AST_ARRIVAL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld[LAST] |=> (pend_vld && pend_tag == $past(src_tag[LAST]))); // R7

endmodule

// File: rtl/mdadd_late_add.sv
module mdadd_late_add #(
  parameter int WORD_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [TAG_W-1:0]    take_tag,
  input  logic [2*WORD_W-1:0] prod_sum,
  input  logic [2*WORD_W-1:0] prod_carry,
  input  logic [WORD_W-1:0]   add_c,
  input  logic [WORD_W-1:0]   add_d,
  output logic                res_vld,
  output logic [TAG_W-1:0]    res_tag,
  output logic [WORD_W-1:0]   res_hi,
  output logic [WORD_W-1:0]   res_lo
);
  localparam int DW = 2 * WORD_W;

  logic [DW-1:0] c_ext, d_ext;
  logic [DW-1:0] s1, k1, s2, k2, total;
  logic          vld_q, vld_d;
  logic [TAG_W-1:0] tag_q;
  logic [DW-1:0]    val_q;

  // Four operands to two with two 3:2 levels, then a single carry-propagate add.
  always_comb begin
    c_ext = DW'(add_c);
    d_ext = DW'(add_d);
    s1    = prod_sum ^ prod_carry ^ c_ext;
    k1    = ((prod_sum & prod_carry) | (prod_sum & c_ext) | (prod_carry & c_ext)) << 1;
    s2    = s1 ^ k1 ^ d_ext;
    k2    = ((s1 & k1) | (s1 & d_ext) | (k1 & d_ext)) << 1;
    total = s2 + k2;
    vld_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      tag_q <= take_tag;
      val_q <= total;
    end
  end

  assign res_vld = vld_q;
  assign res_tag = tag_q;
  assign res_hi  = val_q[DW-1:WORD_W];
  assign res_lo  = val_q[WORD_W-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ({res_hi, res_lo} >= (DW'($past(add_c)) + DW'($past(add_d))))); // R1

endmodule

// File: rtl/mdadd_unit.sv
module mdadd_unit #(
  parameter int WORD_W     = 32,
  parameter int TAG_W      = 4,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_vld,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [WORD_W-1:0] iss_a,
  input  logic [WORD_W-1:0] iss_b,
  input  logic              add_vld,
  input  logic [TAG_W-1:0]  add_tag,
  input  logic [WORD_W-1:0] add_c,
  input  logic [WORD_W-1:0] add_d,
  output logic              res_vld,
  output logic [TAG_W-1:0]  res_tag,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo
);
  localparam int DW = 2 * WORD_W;

  logic [DW-1:0]    tree_sum, tree_carry;
  logic             pend_vld;
  logic [TAG_W-1:0] pend_tag;
  logic [DW-1:0]    pend_sum, pend_carry;
  logic             accept;

  mdadd_pp_tree #(.WORD_W(WORD_W)) u_tree (
    .op_a    (iss_a),
    .op_b    (iss_b),
    .sum_o   (tree_sum),
    .carry_o (tree_carry)
  );

  mdadd_prod_pipe #(.DW(DW), .TAG_W(TAG_W), .STAGES(MUL_STAGES)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (iss_vld),
    .in_tag     (iss_tag),
    .in_sum     (tree_sum),
    .in_carry   (tree_carry),
    .take       (accept),
    .pend_vld   (pend_vld),
    .pend_tag   (pend_tag),
    .pend_sum   (pend_sum),
    .pend_carry (pend_carry)
  );

  // Addends are taken only against a pending product carrying the same tag.
  assign accept = add_vld & pend_vld & (add_tag == pend_tag);

  mdadd_late_add #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_add (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (accept),
    .take_tag   (pend_tag),
    .prod_sum   (pend_sum),
    .prod_carry (pend_carry),
    .add_c      (add_c),
    .add_d      (add_d),
    .res_vld    (res_vld),
    .res_tag    (res_tag),
    .res_hi     (res_hi),
    .res_lo     (res_lo)
  );

  AST_RES_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(add_vld && pend_vld && add_tag == pend_tag)); // R4

  AST_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (add_vld && pend_vld && add_tag != pend_tag) |=> !res_vld); // R5

  AST_RES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_tag == $past(add_tag))); // R8

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vld |=> !res_vld); // R5

endmodule

// File: tb/mdadd_unit_test.sv
module mdadd_unit_test;
  logic        clk;
  logic        rst_n;
  logic        iss_vld;
  logic [3:0]  iss_tag;
  logic [31:0] iss_a, iss_b;
  logic        add_vld;
  logic [3:0]  add_tag;
  logic [31:0] add_c, add_d;
  logic        res_vld;
  logic [3:0]  res_tag;
  logic [31:0] res_hi, res_lo;

  int total;
  int passed;

  mdadd_unit #(.WORD_W(32), .TAG_W(4), .MUL_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_a(iss_a), .iss_b(iss_b),
    .add_vld(add_vld), .add_tag(add_tag), .add_c(add_c), .add_d(add_d),
    .res_vld(res_vld), .res_tag(res_tag), .res_hi(res_hi), .res_lo(res_lo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] model(input logic [31:0] a, b, c, d);
    return ({32'd0, a} * {32'd0, b}) + {32'd0, c} + {32'd0, d};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic ok,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic chk_res(input string req, input logic [3:0] tag, input logic [63:0] val);
    chk({req, " res_vld"}, res_vld == 1'b1, 64'(res_vld), 64'd1);
    chk({req, " R8 tag"}, res_tag == tag, 64'(res_tag), 64'(tag));
    chk({req, " R1 value"}, {res_hi, res_lo} == val, {res_hi, res_lo}, val);
  endtask

  task automatic chk_quiet(input string req);
    chk({req, " res_vld low"}, res_vld == 1'b0, 64'(res_vld), 64'd0);
  endtask

  task automatic issue(input logic [3:0] tag, input logic [31:0] a, b);
    iss_vld = 1'b1; iss_tag = tag; iss_a = a; iss_b = b;
  endtask

  task automatic addends(input logic [3:0] tag, input logic [31:0] c, d);
    add_vld = 1'b1; add_tag = tag; add_c = c; add_d = d;
  endtask

  task automatic idle();
    iss_vld = 1'b0;
    add_vld = 1'b0;
  endtask

  // R9 and R5: quiet through reset, addends with nothing pending are ignored.
  task automatic t_reset();
    rst_n = 1'b0;
    idle();
    iss_tag = '0; iss_a = '0; iss_b = '0;
    addends(4'd0, 32'd1, 32'd2);
    repeat (3) tick();
    chk_quiet("R9 in reset");
    rst_n = 1'b1;
    tick();
    chk_quiet("R9 after release");
    tick();
    chk_quiet("R5 addends with nothing pending");
    idle();
    tick();
  endtask

  // Single operation at the earliest legal addend edge: R1, R4, R8.
  task automatic t_basic(input string req, input logic [3:0] tag,
                         input logic [31:0] a, b, c, d);
    issue(tag, a, b);
    tick();
    idle();
    tick();
    addends(tag, c, d);
    tick();
    chk_res({req, " R4 one cycle"}, tag, model(a, b, c, d));
    idle();
    tick();
    chk_quiet({req, " R4 single pulse"});
  endtask

  // R3: addends sampled one edge too early give nothing; the next edge is accepted.
  task automatic t_early();
    issue(4'd5, 32'h0001_0003, 32'h0000_0007);
    addends(4'd5, 32'd9, 32'd9);
    tick();
    idle();
    addends(4'd5, 32'd100, 32'd200);
    tick();
    chk_quiet("R3 early addends");
    tick();
    chk_res("R3 first legal edge", 4'd5, model(32'h0001_0003, 32'h7, 32'd100, 32'd200));
    idle();
    tick();
  endtask

  // R5, R6: wrong tags ignored, product waits, then repeat use is ignored.
  task automatic t_wait();
    issue(4'd2, 32'hCAFE_F00D, 32'h8000_0001);
    tick();
    idle();
    tick();
    for (int i = 0; i < 3; i++) begin
      addends(4'd3, 32'd1, 32'd1);
      tick();
      chk_quiet("R5 wrong tag");
    end
    idle();
    repeat (20) tick();
    addends(4'd2, 32'h1234_5678, 32'hFFFF_0000);
    tick();
    chk_res("R6 long wait", 4'd2, model(32'hCAFE_F00D, 32'h8000_0001, 32'h1234_5678, 32'hFFFF_0000));
    addends(4'd2, 32'd5, 32'd5);
    tick();
    chk_quiet("R5 consumed product");
    idle();
    tick();
  endtask

  // R2, R11: back-to-back issues, each consumed on the edge its successor lands.
  task automatic t_stream();
    logic [31:0] av [4];
    logic [31:0] bv [4];
    logic [31:0] cv [4];
    logic [31:0] dv [4];
    for (int i = 0; i < 4; i++) begin
      av[i] = 32'h1111_1111 * (i + 3);
      bv[i] = 32'hF0F0_0F0F ^ (i * 32'h0101_0101);
      cv[i] = 32'hFFFF_FFF0 + i;
      dv[i] = 32'h0000_1000 << i;
    end
    for (int t = 0; t < 6; t++) begin
      idle();
      if (t < 4) issue(4'(8 + t), av[t], bv[t]);
      if (t >= 2) addends(4'(8 + t - 2), cv[t-2], dv[t-2]);
      tick();
      if (t >= 2)
        chk_res("R2 R11 stream", 4'(8 + t - 2), model(av[t-2], bv[t-2], cv[t-2], dv[t-2]));
      else
        chk_quiet("R2 stream fill");
    end
    idle();
    tick();
    chk_quiet("R2 stream drained");
  endtask

  // R7: a later arrival replaces an unconsumed product.
  task automatic t_overwrite();
    issue(4'd6, 32'd1000, 32'd1000);
    tick();
    issue(4'd7, 32'd3, 32'd4);
    tick();
    idle();
    tick();
    addends(4'd6, 32'd1, 32'd1);
    tick();
    chk_quiet("R7 replaced tag");
    addends(4'd7, 32'd10, 32'd20);
    tick();
    chk_res("R7 newer product", 4'd7, model(32'd3, 32'd4, 32'd10, 32'd20));
    idle();
    tick();
  endtask

  initial begin
    total = 0;
    passed = 0;
    t_reset();
    t_basic("R1 small", 4'd1, 32'd3, 32'd5, 32'd7, 32'd11);
    t_basic("R1 mixed", 4'd4, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF, 32'd1);
    t_basic("R1 zero multiplier", 4'd9, 32'h89AB_CDEF, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_basic("R10 all ones", 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_early();
    t_wait();
    t_stream();
    t_overwrite();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule